// File: doc/BRIEF.md
# Serial Shift Register with Output Latch

This block is the byte-wide data path of a small general-purpose serial port. An 8-bit shift register can be loaded and read by the CPU. On every shift event it moves one place toward its most significant bit and takes the serial input into bit 0. A two-bit select field picks the source of the shift events: a software strobe, a timer compare-match pulse, or one edge of an external serial clock. The external clock passes through a two-flop synchroniser before its edges are detected.

The serial output comes from the register MSB through a latch. With an internal source the latch is always open, so a CPU write of a new MSB reaches the pin in the same cycle. With the external clock it is open only in the half period that ends at the sampling edge. Input is therefore taken on one clock edge and output changes on the other. When an external bit counter reports a finished transfer, the register value is copied into a read-only buffer. The CPU can then read the received byte at its leisure. No serial wiring mode has to be enabled for the data path to work.

Top module: `ser_shift_path`

## Requirements
- R1: While `rst_n` is low at a clock edge, the shift register, the buffer and `sdo` all become 0.
- R2: A cycle with `wr_en` high loads `wr_data` into the shift register at that edge, and `shift_q` reads it back from the next cycle on.
- R3: When `wr_en` and a selected shift event fall in the same cycle, the register takes `wr_data` and does not shift.
- R4: A shift event without a write sets the register to `{shift_q[6:0], sdi}` at that edge.
- R5: `clk_sel` encodes the shift source: 0 = software strobe (`sw_strobe`), 1 = timer match (`timer_match`), 2 = rising edge of `sck`, 3 = falling edge of `sck`. Events from a source that is not selected leave the register unchanged.
- R6: With an external source, the shift caused by an `sck` transition takes place at the third rising system-clock edge after the transition.
- R7: With an external source, `sdo` follows the MSB only while the synchronised `sck` is at the level opposite its sampling edge (low for mode 2, high for mode 3). Otherwise `sdo` keeps the MSB it held when that phase began.
- R8: With an internal source (mode 0 or 1), `sdo` equals `shift_q[7]` in every cycle, including the cycle right after a write.
- R9: A cycle with `xfer_done` high copies the current shift register value into `buf_q`. CPU writes and shifts leave `buf_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for the shift register |
| wr_data | input | 8 | CPU write data |
| clk_sel | input | 2 | Shift source select (see R5) |
| sw_strobe | input | 1 | One-cycle software shift strobe |
| timer_match | input | 1 | One-cycle timer compare-match pulse |
| xfer_done | input | 1 | One-cycle transfer-complete pulse from the bit counter |
| sdi | input | 1 | Serial data input |
| sck | input | 1 | Asynchronous external serial clock |
| sdo | output | 1 | Serial data output |
| shift_q | output | 8 | CPU read of the shift register |
| buf_q | output | 8 | CPU read of the receive buffer |

## Verification
In every cycle, the assertions check the next-state rules of the shift register and the buffer: write priority, the one-place shift with `sdi` entering, holding when nothing happens, buffer capture and buffer hold. They also check that a closed output latch keeps `sdo` steady. Only the bench scenarios can show the three-cycle latency of the synchronised external clock. The same holds for the choice between the rising-edge and falling-edge modes, for the half period in which `sdo` lags a completed shift, and for source events that are ignored because another source is selected.

// File: rtl/ssp_pkg.sv
// Package: shared encodings of the serial shift path.
// Assumes: clk_sel values are fixed because software programs them.
package ssp_pkg;
    typedef enum logic [1:0] {
        SEL_SOFT     = 2'd0,
        SEL_TIMER    = 2'd1,
        SEL_EXT_RISE = 2'd2,
        SEL_EXT_FALL = 2'd3
    } ssp_sel_e;
endpackage

// File: rtl/ssp_edge_sync.sv
// Module: brings an asynchronous clock into the system clock domain with a
// flop chain and reports its level and single-cycle rise/fall pulses.
// Assumes: the input is slow against clk (at least a few cycles per level).
module ssp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    // Shift the asynchronous input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], async_in};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[LAST];
    end

    assign level = chain[LAST];
    assign rise  = chain[LAST] & ~prev;
    assign fall  = ~chain[LAST] & prev;
endmodule

// File: rtl/ssp_shift_core.sv
// Module: the CPU-visible shift register and its receive buffer.
// A write has priority over a shift, and a shift moves the register left with
// sdi entering at bit 0. The buffer copies the register on a transfer-done pulse.
// Assumes: shift_en and xfer_done are single-cycle pulses in the clk domain.
module ssp_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         shift_en,
    input  logic         sdi,
    input  logic         xfer_done,
    output logic [W-1:0] data_q,
    output logic [W-1:0] buf_q
);
    localparam int MSB = W - 1;

    // Update the shift register: write first, then shift, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (wr_en)    data_q <= wr_data;
        else if (shift_en) data_q <= {data_q[MSB-1:0], sdi};
    end

    // Capture the completed byte into the read-only buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)         buf_q <= '0;
        else if (xfer_done) buf_q <= data_q;
    end

    // R3
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> data_q == $past(wr_data));

    // R4
    left_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && shift_en) |=> data_q == {$past(data_q[MSB-1:0]), $past(sdi)});

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !shift_en) |=> $stable(data_q));

    // R9
    buf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> buf_q == $past(data_q));

    // R9
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |=> $stable(buf_q));
endmodule

// File: rtl/ssp_out_latch.sv
// Module: output latch built from a hold flop and a bypass mux. When open, the
// output follows the input in the same cycle. When closed, it shows the value
// captured on the last open cycle.
// Assumes: open_en is a clean clk-domain signal.
module ssp_out_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic open_en,
    input  logic d,
    output logic q
);
    logic held;

    // Track the input while open so the value is kept when the latch closes.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= 1'b0;
        else if (open_en) held <= d;
    end

    assign q = open_en ? d : held;

    // R7
    closed_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_en && $past(!open_en)) |-> $stable(q));
endmodule

// File: rtl/ser_shift_path.sv
// Module: top of the serial shift path. It selects the shift source, feeds
// the shift core and drives sdo from the MSB through the output latch.
// Assumes: sdi is stable around the selected sampling edge. sck is
// asynchronous and is synchronised here.
module ser_shift_path #(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        clk_sel,
    input  logic              sw_strobe,
    input  logic              timer_match,
    input  logic              xfer_done,
    input  logic              sdi,
    input  logic              sck,
    output logic              sdo,
    output logic [DATA_W-1:0] shift_q,
    output logic [DATA_W-1:0] buf_q
);
    import ssp_pkg::*;

    localparam int MSB = DATA_W - 1;

    logic sck_lvl, sck_rise, sck_fall;
    logic shift_evt, latch_open;

    ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(sck),
        .level   (sck_lvl),
        .rise    (sck_rise),
        .fall    (sck_fall)
    );

    // Pick the shift event and the latch phase for the selected source.
    always_comb begin
        case (ssp_sel_e'(clk_sel))
            SEL_SOFT:     begin shift_evt = sw_strobe;   latch_open = 1'b1;     end
            SEL_TIMER:    begin shift_evt = timer_match; latch_open = 1'b1;     end
            SEL_EXT_RISE: begin shift_evt = sck_rise;    latch_open = ~sck_lvl; end
            default:      begin shift_evt = sck_fall;    latch_open = sck_lvl;  end
        endcase
    end

    ssp_shift_core #(.W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .shift_en (shift_evt),
        .sdi      (sdi),
        .xfer_done(xfer_done),
        .data_q   (shift_q),
        .buf_q    (buf_q)
    );

    ssp_out_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_en(latch_open),
        .d      (shift_q[MSB]),
        .q      (sdo)
    );

    // R8
    internal_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_sel[1] |-> sdo == shift_q[MSB]);
endmodule

// File: tb/sim_ser_shift_path.sv
`timescale 1ns/1ps
module sim_ser_shift_path;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] clk_sel = '0;
    logic       sw_strobe = 1'b0;
    logic       timer_match = 1'b0;
    logic       xfer_done = 1'b0;
    logic       sdi = 1'b0;
    logic       sck = 1'b0;
    logic       sdo;
    logic [7:0] shift_q, buf_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ser_shift_path u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .clk_sel(clk_sel), .sw_strobe(sw_strobe), .timer_match(timer_match),
        .xfer_done(xfer_done), .sdi(sdi), .sck(sck), .sdo(sdo),
        .shift_q(shift_q), .buf_q(buf_q)
    );

    // Vector: {wr, wdata[7:0], sel[1:0], strobe, timer, sdi, expected[7:0]}
    localparam int NV = 8;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 8'hA5, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA5},  // R2 load
        {1'b0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b1, 8'h4B},  // R4 strobe shift
        {1'b0, 8'h00, 2'd0, 1'b0, 1'b1, 1'b1, 8'h4B},  // R5 timer ignored
        {1'b0, 8'h00, 2'd1, 1'b0, 1'b1, 1'b0, 8'h96},  // R5 timer shift
        {1'b0, 8'h00, 2'd1, 1'b1, 1'b0, 1'b1, 8'h96},  // R5 strobe ignored
        {1'b1, 8'h3C, 2'd1, 1'b0, 1'b1, 1'b1, 8'h3C},  // R3 write beats timer
        {1'b1, 8'h81, 2'd0, 1'b1, 1'b0, 1'b0, 8'h81},  // R3 write beats strobe
        {1'b0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 8'h02}   // R4 shift, sdi 0
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        tick(3);
        check("R1 shift", shift_q, 8'h00);
        check("R1 buf", buf_q, 8'h00);
        check("R1 sdo", {7'b0, sdo}, 8'h00);
        rst_n = 1'b1;
        tick(1);

        for (int v = 0; v < NV; v++) begin
            wr_en       = VEC[v][21];
            wr_data     = VEC[v][20:13];
            clk_sel     = VEC[v][12:11];
            sw_strobe   = VEC[v][10];
            timer_match = VEC[v][9];
            sdi         = VEC[v][8];
            tick(1);
            wr_en = 1'b0; sw_strobe = 1'b0; timer_match = 1'b0;
            check("R2-R5 vector", shift_q, VEC[v][7:0]);
            check("R8 sdo", {7'b0, sdo}, {7'b0, VEC[v][7]});
        end

        // R9: capture, then writes leave the buffer alone
        xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
        check("R9 capture", buf_q, 8'h02);
        wr_en = 1'b1; wr_data = 8'hFF; tick(1); wr_en = 1'b0;
        check("R9 hold", buf_q, 8'h02);
        check("R8 same-cycle msb", {7'b0, sdo}, 8'h01);

        // R6/R7: rising-edge external mode
        clk_sel = 2'd2; sdi = 1'b0;
        wr_en = 1'b1; wr_data = 8'h80; tick(1); wr_en = 1'b0;
        check("R7 open low", {7'b0, sdo}, 8'h01);
        sck = 1'b1;
        tick(2);
        check("R6 no shift yet", shift_q, 8'h80);
        tick(1);
        check("R6 shift third edge", shift_q, 8'h00);
        check("R7 held while high", {7'b0, sdo}, 8'h01);
        sck = 1'b0;
        tick(1);
        check("R7 still held", {7'b0, sdo}, 8'h01);
        tick(1);
        check("R7 reopened", {7'b0, sdo}, 8'h00);

        // R5: falling-edge external mode ignores rising edges
        clk_sel = 2'd3; sdi = 1'b1;
        wr_en = 1'b1; wr_data = 8'h40; tick(1); wr_en = 1'b0;
        sck = 1'b1; tick(4);
        check("R5 rise ignored", shift_q, 8'h40);
        sck = 1'b0; tick(4);
        check("R5 fall shift", shift_q, 8'h81);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule